// File: doc/BRIEF.md
# SDRAM Power-Up and Self-Refresh Command Sequencer

This block generates the command stream that brings an SDRAM from power-up to a usable state, and that moves it into and out of self-refresh. Software starts initialization by writing a start bit to a small configuration register. The register also holds an order bit that chooses between two command orders, a clock-keep bit, and two geometry fields that set how many column and row address bits the memory uses. The command is driven on the chip-select, row-strobe, column-strobe and write-enable pins. The mode word and the all-bank precharge flag go out on the address bus.

Once initialized, a level request puts the memory into self-refresh. The block issues a refresh command with clock-enable low. If clock-keep is clear, it then stops the memory clock until the request drops. On exit it restarts the clock, raises clock-enable, and waits out the exit recovery time before it reports ready. When the bus is released and clock-keep is clear, the clock pin is tri-stated. There are two resets. A cold reset restores every field. A warm reset only restarts the sequencer and keeps the configuration.

Top module: `sdr_init_seq`

## Requirements
- R1: After a cold reset the order bit is 0, clock-keep is 1, both geometry fields are 0, busy and ready are 0, clock-enable is 1, and the command pins {cs_n,ras_n,cas_n,we_n} show the no-operation code 0111.
- R2: With order 0, initialization issues precharge (0010), then REF_CNT auto-refresh commands (0001), then mode register set (0000).
- R3: With order 1, initialization issues precharge, then mode register set, then REF_CNT auto-refresh commands.
- R4: Precharge drives address bit 10 high and all other address bits low. Mode register set drives MODE_VALUE on the address bus. Every other command drives address 0.
- R5: A command is followed by no-operation cycles before the next command: T_RP after precharge, T_RC after each refresh, and T_MRD after mode register set.
- R6: Busy reads 1 from the cycle after the start write until the wait after the last command has elapsed. The start bit then clears itself, busy falls, and ready rises in the same cycle.
- R7: Without a start write no command leaves the block. A configuration write made while busy is 1 changes nothing.
- R8: A warm reset clears busy and ready and keeps the order, clock-keep and geometry fields.
- R9: A self-refresh request seen while ready issues one refresh command with clock-enable 0. Clock-enable then stays 0 while the request is held. The clock enable output equals clock-keep during the hold, and it is 1 in the cycle of the refresh command.
- R10: When the request drops, the clock enable is 1 with clock-enable still 0 for one cycle. Clock-enable then rises, and ready returns after T_XSR further cycles.
- R11: The clock output enable is 0 exactly when bus release is 1 and clock-keep is 0.
- R12: The column field gives 8, 9 or 10 column address bits for codes 0, 1 and 2. The row field gives 11, 12 or 13 row address bits for codes 0, 1 and 2. Code 3 of either field acts as code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset, restores all fields |
| warm_rst | input | 1 | Synchronous warm reset, restarts the sequencer only |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_start | input | 1 | Start value written with the strobe |
| cfg_order_i | input | 1 | Order select value to write |
| cfg_keep_i | input | 1 | Clock-keep value to write |
| cfg_col_i | input | 2 | Column geometry code to write |
| cfg_row_i | input | 2 | Row geometry code to write |
| cfg_order_o | output | 1 | Current order select |
| cfg_keep_o | output | 1 | Current clock-keep |
| cfg_col_o | output | 2 | Current column code |
| cfg_row_o | output | 2 | Current row code |
| sr_req | input | 1 | Self-refresh request level |
| bus_rel | input | 1 | Bus released to another master |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Memory clock-enable |
| sd_addr | output | ADDR_W | Address bus for precharge flag and mode word |
| sd_clk_en | output | 1 | Memory clock gate enable |
| sd_clk_oe | output | 1 | Memory clock pin output enable |
| busy | output | 1 | Initialization in progress (start bit) |
| ready | output | 1 | Initialized, idle and accepting requests |
| col_bits | output | 4 | Number of column address bits in use |
| row_bits | output | 4 | Number of row address bits in use |

## Verification
Initialization is run with both values of the order bit. Each issued command is recorded with its cycle, and the record is compared against a schedule built from the wait parameters. This separates a swapped order, a wrong refresh count and a wait that is off by one cycle. A configuration write made while busy shows whether writes are ignored during a run, and a warm reset in the middle of a run shows which state is kept. Self-refresh is run with clock-keep both set and clear, so that gating the clock can be told apart from keeping it running. Bus release is tried under all four combinations with clock-keep.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_WRP,
      ST_REF,
      ST_WRC,
      ST_MRS,
      ST_WMRD,
      ST_SRE,
      ST_SRH,
      ST_SRC,
      ST_SRX
   } seq_state_e;

   typedef struct packed {
      logic       order;
      logic       keep;
      logic [1:0] col;
      logic [1:0] row;
   } seq_cfg_t;

   localparam seq_cfg_t CFG_COLD = '{order: 1'b0, keep: 1'b1, col: 2'd0, row: 2'd0};

   function automatic logic [3:0] geo_bits(input logic [1:0] code, input logic [3:0] base);
      logic [1:0] sel;
      sel = (code == 2'd3) ? 2'd2 : code;
      return base + {2'b00, sel};
   endfunction

endpackage

// File: rtl/sdr_seq_cfg.sv
module sdr_seq_cfg
   import sdr_seq_pkg::*;
(
   input  logic     clk,
   input  logic     cold_rst_n,
   input  logic     warm_rst,
   input  logic     wr_en,
   input  logic     wr_start,
   input  seq_cfg_t wr_cfg,
   input  logic     seq_done,
   output seq_cfg_t cfg,
   output logic     start_q
);

   // Configuration survives the warm reset; only the start bit is cleared by it.
   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
         cfg     <= CFG_COLD;
         start_q <= 1'b0;
      end else if (warm_rst) begin
         start_q <= 1'b0;
      end else if (seq_done) begin
         start_q <= 1'b0;
      end else if (wr_en && !start_q) begin
         cfg     <= wr_cfg;
         start_q <= wr_start;
      end
   end

endmodule

// File: rtl/sdr_seq_timer.sv
module sdr_seq_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
   import sdr_seq_pkg::*;
#(
   parameter int REF_CNT = 8,
   parameter int T_RP    = 2,
   parameter int T_RC    = 6,
   parameter int T_MRD   = 2,
   parameter int T_XSR   = 8,
   parameter int CNT_W   = 4
) (
   input  logic             clk,
   input  logic             cold_rst_n,
   input  logic             warm_rst,
   input  logic             start,
   input  logic             order,
   input  logic             sr_req,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output seq_state_e       state,
   output logic             done,
   output logic             init_done
);

   localparam int RW = (REF_CNT > 1) ? $clog2(REF_CNT) : 1;

   seq_state_e nxt;
   logic [RW-1:0] ref_left;

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      done     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start)                    nxt = ST_PRE;
            else if (sr_req && init_done) nxt = ST_SRE;
         end
         ST_PRE: begin
            nxt      = ST_WRP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RP - 1);
         end
         ST_WRP: if (tmr_zero) nxt = order ? ST_MRS : ST_REF;
         ST_REF: begin
            nxt      = ST_WRC;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RC - 1);
         end
         ST_WRC: begin
            if (tmr_zero) begin
               if (ref_left != '0) nxt = ST_REF;
               else if (order) begin
                  nxt  = ST_IDLE;
                  done = 1'b1;
               end else nxt = ST_MRS;
            end
         end
         ST_MRS: begin
            nxt      = ST_WMRD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_MRD - 1);
         end
         ST_WMRD: begin
            if (tmr_zero) begin
               if (order) nxt = ST_REF;
               else begin
                  nxt  = ST_IDLE;
                  done = 1'b1;
               end
            end
         end
         ST_SRE: nxt = ST_SRH;
         ST_SRH: if (!sr_req) nxt = ST_SRC;
         ST_SRC: begin
            nxt      = ST_SRX;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_XSR - 1);
         end
         ST_SRX: if (tmr_zero) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
         state     <= ST_IDLE;
         ref_left  <= '0;
         init_done <= 1'b0;
      end else if (warm_rst) begin
         state     <= ST_IDLE;
         ref_left  <= '0;
         init_done <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_PRE)
            ref_left <= RW'(REF_CNT - 1);
         else if (state == ST_WRC && tmr_zero && ref_left != '0)
            ref_left <= ref_left - 1'b1;
         if (done) init_done <= 1'b1;
      end
   end

endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
   import sdr_seq_pkg::*;
#(
   parameter int                ADDR_W     = 13,
   parameter int                REF_CNT    = 8,
   parameter int                T_RP       = 2,
   parameter int                T_RC       = 6,
   parameter int                T_MRD      = 2,
   parameter int                T_XSR      = 8,
   parameter logic [ADDR_W-1:0] MODE_VALUE = ADDR_W'(13'h0032)
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst,
   input  logic              cfg_we,
   input  logic              cfg_start,
   input  logic              cfg_order_i,
   input  logic              cfg_keep_i,
   input  logic [1:0]        cfg_col_i,
   input  logic [1:0]        cfg_row_i,
   output logic              cfg_order_o,
   output logic              cfg_keep_o,
   output logic [1:0]        cfg_col_o,
   output logic [1:0]        cfg_row_o,
   input  logic              sr_req,
   input  logic              bus_rel,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic              sd_cke,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              sd_clk_en,
   output logic              sd_clk_oe,
   output logic              busy,
   output logic              ready,
   output logic [3:0]        col_bits,
   output logic [3:0]        row_bits
);

   localparam int T_MAX1 = (T_RP > T_RC) ? T_RP : T_RC;
   localparam int T_MAX2 = (T_MRD > T_XSR) ? T_MRD : T_XSR;
   localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
   localparam int CNT_W  = $clog2(T_MAX + 1);
   localparam int A10    = 10;

   generate
      if (ADDR_W < 13) begin : g_bad_addr
         $error("sdr_init_seq: ADDR_W must cover 13 row address bits");
      end
      if (REF_CNT < 1 || T_RP < 1 || T_RC < 1 || T_MRD < 1 || T_XSR < 1) begin : g_bad_time
         $error("sdr_init_seq: counts and waits must be at least 1");
      end
   endgenerate

   seq_cfg_t         cfg, wr_cfg;
   logic             start_q, done, init_done;
   logic             tmr_load, tmr_zero, tmr_clr;
   logic [CNT_W-1:0] tmr_val;
   seq_state_e       state;
   sdr_cmd_e         cmd;
   logic             is_pre, is_mrs;

   assign wr_cfg = '{order: cfg_order_i, keep: cfg_keep_i, col: cfg_col_i, row: cfg_row_i};
   assign tmr_clr = warm_rst;

   sdr_seq_cfg u_cfg (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .warm_rst   (warm_rst),
      .wr_en      (cfg_we),
      .wr_start   (cfg_start),
      .wr_cfg     (wr_cfg),
      .seq_done   (done),
      .cfg        (cfg),
      .start_q    (start_q)
   );

   sdr_seq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (cold_rst_n),
      .clr      (tmr_clr),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sdr_seq_fsm #(
      .REF_CNT (REF_CNT),
      .T_RP    (T_RP),
      .T_RC    (T_RC),
      .T_MRD   (T_MRD),
      .T_XSR   (T_XSR),
      .CNT_W   (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .warm_rst   (warm_rst),
      .start      (start_q),
      .order      (cfg.order),
      .sr_req     (sr_req),
      .tmr_zero   (tmr_zero),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .state      (state),
      .done       (done),
      .init_done  (init_done)
   );

   always_comb begin
      unique case (state)
         ST_PRE:         cmd = CMD_PRE;
         ST_REF, ST_SRE: cmd = CMD_REF;
         ST_MRS:         cmd = CMD_MRS;
         default:        cmd = CMD_NOP;
      endcase
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign is_pre = (state == ST_PRE);
   assign is_mrs = (state == ST_MRS);

   generate
      for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
         if (i == A10) begin : g_ap
            assign sd_addr[i] = is_pre | (is_mrs & MODE_VALUE[i]);
         end else begin : g_plain
            assign sd_addr[i] = is_mrs & MODE_VALUE[i];
         end
      end
   endgenerate

   assign sd_cke    = !(state == ST_SRE || state == ST_SRH || state == ST_SRC);
   assign sd_clk_en = !(state == ST_SRH && !cfg.keep);
   assign sd_clk_oe = cfg.keep | !bus_rel;

   assign busy  = start_q;
   assign ready = init_done && (state == ST_IDLE) && !start_q;

   assign cfg_order_o = cfg.order;
   assign cfg_keep_o  = cfg.keep;
   assign cfg_col_o   = cfg.col;
   assign cfg_row_o   = cfg.row;
   assign col_bits    = geo_bits(cfg.col, 4'd8);
   assign row_bits    = geo_bits(cfg.row, 4'd11);

endmodule

// File: rtl/sdr_init_seq_chk.sv
module sdr_init_seq_chk #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              cold_rst_n,
   input logic              warm_rst,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic              sd_cke,
   input logic [ADDR_W-1:0] sd_addr,
   input logic              sd_clk_en,
   input logic              busy,
   input logic              ready,
   input logic              cfg_order_o,
   input logic              cfg_keep_o,
   input logic [1:0]        cfg_col_o,
   input logic [1:0]        cfg_row_o
);

   logic [3:0] cmd;
   assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   p_pre_a10_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (cmd == 4'b0010) |-> sd_addr[10]);

   p_fell_ready_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
      ($fell(busy) && !$past(warm_rst)) |-> ready);

   p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
      ready |-> (cmd == 4'b0111 && sd_cke && !busy));

   p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
      busy |=> $stable({cfg_order_o, cfg_keep_o, cfg_col_o, cfg_row_o}));

   p_busy_cke_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
      busy |-> sd_cke);

   p_sr_hold_r9: assert property (@(posedge clk) disable iff (!cold_rst_n || warm_rst)
      (cmd == 4'b0001 && !sd_cke) |=> !sd_cke);

   p_clkstop_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !sd_clk_en |-> !sd_cke);

endmodule

bind sdr_init_seq sdr_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .cold_rst_n  (cold_rst_n),
   .warm_rst    (warm_rst),
   .sd_cs_n     (sd_cs_n),
   .sd_ras_n    (sd_ras_n),
   .sd_cas_n    (sd_cas_n),
   .sd_we_n     (sd_we_n),
   .sd_cke      (sd_cke),
   .sd_addr     (sd_addr),
   .sd_clk_en   (sd_clk_en),
   .busy        (busy),
   .ready       (ready),
   .cfg_order_o (cfg_order_o),
   .cfg_keep_o  (cfg_keep_o),
   .cfg_col_o   (cfg_col_o),
   .cfg_row_o   (cfg_row_o)
);

// File: tb/sdr_init_seq_tb.sv
module sdr_init_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 13;
   localparam int NREF  = 8;
   localparam int TRP   = 2;
   localparam int TRC   = 6;
   localparam int TMRD  = 2;
   localparam int TXSR  = 8;
   localparam logic [AW-1:0] MODE = 13'h0032;

   logic clk = 1'b0;
   logic cold_rst_n = 1'b0, warm_rst = 1'b0;
   logic cfg_we = 1'b0, cfg_start = 1'b0, cfg_order_i = 1'b0, cfg_keep_i = 1'b1;
   logic [1:0] cfg_col_i = 2'd0, cfg_row_i = 2'd0;
   logic cfg_order_o, cfg_keep_o;
   logic [1:0] cfg_col_o, cfg_row_o;
   logic sr_req = 1'b0, bus_rel = 1'b0;
   logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_clk_en, sd_clk_oe;
   logic [AW-1:0] sd_addr;
   logic busy, ready;
   logic [3:0] col_bits, row_bits;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdr_init_seq #(
      .ADDR_W(AW), .REF_CNT(NREF), .T_RP(TRP), .T_RC(TRC),
      .T_MRD(TMRD), .T_XSR(TXSR), .MODE_VALUE(MODE)
   ) u_dut (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst),
      .cfg_we(cfg_we), .cfg_start(cfg_start), .cfg_order_i(cfg_order_i),
      .cfg_keep_i(cfg_keep_i), .cfg_col_i(cfg_col_i), .cfg_row_i(cfg_row_i),
      .cfg_order_o(cfg_order_o), .cfg_keep_o(cfg_keep_o),
      .cfg_col_o(cfg_col_o), .cfg_row_o(cfg_row_o),
      .sr_req(sr_req), .bus_rel(bus_rel),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_cke(sd_cke), .sd_addr(sd_addr), .sd_clk_en(sd_clk_en), .sd_clk_oe(sd_clk_oe),
      .busy(busy), .ready(ready), .col_bits(col_bits), .row_bits(row_bits)
   );

   function automatic logic [3:0] cmd_now();
      return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // Configuration write; returns at the falling edge right after the write edge.
   task automatic wr(input bit st, input bit ord, input bit kp,
                     input logic [1:0] col, input logic [1:0] row);
      @(negedge clk);
      cfg_we = 1'b1; cfg_start = st; cfg_order_i = ord; cfg_keep_i = kp;
      cfg_col_i = col; cfg_row_i = row;
      @(negedge clk);
      cfg_we = 1'b0; cfg_start = 1'b0;
   endtask

   task automatic t_reset_defaults();
      chk(cfg_order_o == 1'b0, "R1", "order", cfg_order_o, 0);
      chk(cfg_keep_o == 1'b1, "R1", "keep", cfg_keep_o, 1);
      chk(cfg_col_o == 2'd0 && cfg_row_o == 2'd0, "R1", "geometry", {cfg_col_o, cfg_row_o}, 0);
      chk(!busy && !ready, "R1", "busy/ready", {busy, ready}, 0);
      chk(cmd_now() == 4'b0111 && sd_cke, "R1", "cmd/cke", {cmd_now(), sd_cke}, 5'b01111);
      chk(col_bits == 4'd8 && row_bits == 4'd11, "R12", "default bits", {col_bits, row_bits}, 8'h8B);
   endtask

   task automatic t_no_start();
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (cmd_now() != 4'b0111) seen++;
      end
      chk(seen == 0 && !busy, "R7", "commands without start", seen, 0);
   endtask

   // Runs initialization and compares every command against a computed schedule.
   task automatic t_init(input bit ord, input bit kp);
      int exp_t[$]; logic [3:0] exp_c[$]; logic [AW-1:0] exp_a[$];
      int got_t[$]; logic [3:0] got_c[$]; logic [AW-1:0] got_a[$];
      int t = 1;
      int endt;
      int cke_bad = 0;
      string rq;
      rq = ord ? "R3" : "R2";
      exp_t.push_back(t); exp_c.push_back(4'b0010); exp_a.push_back(AW'(1) << 10);
      t += 1 + TRP;
      if (ord) begin
         exp_t.push_back(t); exp_c.push_back(4'b0000); exp_a.push_back(MODE);
         t += 1 + TMRD;
      end
      for (int r = 0; r < NREF; r++) begin
         exp_t.push_back(t); exp_c.push_back(4'b0001); exp_a.push_back('0);
         t += 1 + TRC;
      end
      if (!ord) begin
         exp_t.push_back(t); exp_c.push_back(4'b0000); exp_a.push_back(MODE);
         t += 1 + TMRD;
      end
      endt = t;
      wr(1'b1, ord, kp, cfg_col_o, cfg_row_o);
      for (int k = 0; k <= endt; k++) begin
         if (k == 0) chk(busy == 1'b1, "R6", "busy after start", busy, 1);
         if (cmd_now() != 4'b0111) begin
            got_t.push_back(k); got_c.push_back(cmd_now()); got_a.push_back(sd_addr);
         end
         if (!sd_cke) cke_bad++;
         if (k == endt - 1) chk(busy == 1'b1 && !ready, "R6", "busy before end", {busy, ready}, 2'b10);
         if (k == endt) chk(busy == 1'b0 && ready, "R6", "done at end", {busy, ready}, 2'b01);
         if (k < endt) @(negedge clk);
      end
      chk(got_t.size() == exp_t.size(), rq, "command count", got_t.size(), exp_t.size());
      chk(cke_bad == 0, rq, "cke low during init", cke_bad, 0);
      if (got_t.size() == exp_t.size()) begin
         for (int i = 0; i < exp_t.size(); i++) begin
            chk(got_c[i] == exp_c[i], rq, $sformatf("cmd %0d", i), got_c[i], exp_c[i]);
            chk(got_t[i] == exp_t[i], "R5", $sformatf("cycle of cmd %0d", i), got_t[i], exp_t[i]);
            chk(got_a[i] == exp_a[i], "R4", $sformatf("addr of cmd %0d", i), got_a[i], exp_a[i]);
         end
      end
   endtask

   task automatic t_busy_write_ignored();
      wr(1'b1, 1'b0, 1'b1, 2'd0, 2'd0);
      repeat (3) @(negedge clk);
      wr(1'b1, 1'b1, 1'b0, 2'd2, 2'd2);
      chk(cfg_order_o == 1'b0 && cfg_keep_o == 1'b1 && cfg_col_o == 2'd0 && cfg_row_o == 2'd0,
          "R7", "cfg changed while busy", {cfg_order_o, cfg_keep_o, cfg_col_o, cfg_row_o}, 6'b010000);
      for (int k = 0; k < 400 && busy; k++) @(negedge clk);
      chk(!busy && ready, "R6", "run finishes", {busy, ready}, 2'b01);
   endtask

   task automatic t_geometry();
      wr(1'b0, 1'b0, 1'b1, 2'd1, 2'd1);
      chk(col_bits == 4'd9 && row_bits == 4'd12, "R12", "code 1", {col_bits, row_bits}, 8'h9C);
      wr(1'b0, 1'b0, 1'b1, 2'd2, 2'd2);
      chk(col_bits == 4'd10 && row_bits == 4'd13, "R12", "code 2", {col_bits, row_bits}, 8'hAD);
      wr(1'b0, 1'b0, 1'b1, 2'd3, 2'd3);
      chk(col_bits == 4'd10 && row_bits == 4'd13, "R12", "code 3", {col_bits, row_bits}, 8'hAD);
      wr(1'b0, 1'b0, 1'b1, 2'd0, 2'd0);
   endtask

   task automatic t_selfref(input bit kp);
      chk(ready, "R9", "ready before entry", ready, 1);
      sr_req = 1'b1;
      @(negedge clk);
      chk(cmd_now() == 4'b0001 && !sd_cke && sd_clk_en, "R9", "entry refresh",
          {cmd_now(), sd_cke, sd_clk_en}, 6'b000101);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(cmd_now() == 4'b0111 && !sd_cke && sd_clk_en == kp, "R9", "hold",
             {cmd_now(), sd_cke, sd_clk_en}, {5'b01110, kp});
      end
      sr_req = 1'b0;
      @(negedge clk);
      chk(sd_clk_en && !sd_cke && !ready, "R10", "clock restart", {sd_clk_en, sd_cke, ready}, 3'b100);
      @(negedge clk);
      chk(sd_cke && !ready, "R10", "cke rises", {sd_cke, ready}, 2'b10);
      for (int i = 1; i < TXSR; i++) @(negedge clk);
      chk(!ready, "R10", "ready held in recovery", ready, 0);
      @(negedge clk);
      chk(ready, "R10", "ready after recovery", ready, 1);
   endtask

   task automatic t_clk_oe();
      for (int c = 0; c < 4; c++) begin
         wr(1'b0, cfg_order_o, c[1], cfg_col_o, cfg_row_o);
         bus_rel = c[0];
         #1;
         chk(sd_clk_oe == !(c[0] && !c[1]), "R11", $sformatf("oe case %0d", c),
             sd_clk_oe, !(c[0] && !c[1]));
      end
      bus_rel = 1'b0;
   endtask

   task automatic t_warm();
      wr(1'b0, 1'b1, 1'b0, 2'd1, 2'd2);
      @(negedge clk);
      warm_rst = 1'b1;
      @(negedge clk);
      warm_rst = 1'b0;
      chk(cfg_order_o == 1'b1 && cfg_keep_o == 1'b0 && cfg_col_o == 2'd1 && cfg_row_o == 2'd2,
          "R8", "cfg kept", {cfg_order_o, cfg_keep_o, cfg_col_o, cfg_row_o}, 6'b100110);
      chk(!busy && !ready, "R8", "status cleared", {busy, ready}, 0);
      wr(1'b1, 1'b1, 1'b0, 2'd1, 2'd2);
      repeat (5) @(negedge clk);
      warm_rst = 1'b1;
      @(negedge clk);
      warm_rst = 1'b0;
      chk(!busy && !ready && cmd_now() == 4'b0111, "R8", "warm mid-run",
          {busy, ready, cmd_now()}, 6'b000111);
      chk(cfg_order_o == 1'b1 && cfg_row_o == 2'd2, "R8", "cfg kept mid-run",
          {cfg_order_o, cfg_row_o}, 3'b110);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cold_rst_n = 1'b1;
      @(negedge clk);
      t_reset_defaults();
      t_no_start();
      t_init(1'b0, 1'b1);
      t_selfref(1'b1);
      t_init(1'b1, 1'b0);
      t_selfref(1'b0);
      t_busy_write_ignored();
      t_geometry();
      t_clk_oe();
      t_warm();
      cold_rst_n = 1'b0;
      @(negedge clk);
      cold_rst_n = 1'b1;
      @(negedge clk);
      t_reset_defaults();
      summary();
      $finish;
   end

endmodule